// File: doc/BRIEF.md
# System Control Register Write Unit

This block holds the privileged control registers of a processor's system coprocessor and handles their write path. A write supplies a 5-bit register number, a 3-bit select and a 32-bit value. Each register has its own pair of masks. Bits in the update mask come from the written value. Bits in the preserve mask keep their stored contents. Every other bit is cleared.

Writes to the status and debug registers also refresh a small set of processor mode flags: user mode, exception level, error level and debug mode. A status write can unmask an interrupt that is already pending. The block then raises the hardware interrupt request at once and emits a one-cycle external-interrupt pulse. A status write that turns the global enable off withdraws the request.

A combinational read port returns the stored value of any register. All updates land on the rising clock edge that samples the write strobe.

Top module: `sysctl_wr_unit`

## Requirements
- R1: After synchronous reset, every register reads 0. The user, exception and debug flags are 0, the error-level flag is 1, and both the interrupt request and the pulse are 0.
- R2: A write to register 12 (status) stores the value ANDed with 0xFA78FF01. In the same edge, the user flag takes written bit 4, the error-level flag takes written bit 2 and the exception flag takes written bit 1.
- R3: A write to register 13 (cause) leaves the stored bits under 0xB000F87C unchanged and loads the written bits under 0x00C00300. All other bits become 0.
- R4: A write to register 23 (debug) preserves the stored bits under 0x8C03FC1F and loads the written bits under 0x13300120. The debug-mode flag takes written bit 30.
- R5: A write to register 16 with select 0 preserves the stored bits under 0x8017FF80 and loads the written bits under 0x7E000001.
- R6: Register 19 stores the value ANDed with 0x40FF0FF8. Register 28 with select 0 stores the value ANDed with 0xFFFFFCF6.
- R7: Registers 11, 14, 18, 24, 30 and 31 store all 32 written bits.
- R8: A write changes no register, flag or interrupt output in any of these cases: the register number is not one listed above, registers 16 or 28 are written with a nonzero select, or the write strobe is low. For every other listed register the select is ignored.
- R9: A status write raises the interrupt request and a pulse when all of the following hold: written bit 0 is 1, stored status bit 0 was 0, written bits 1 and 2 are 0, the debug flag is 0, and the written mask bits 15:8 AND the cause pending bits 15:8 are nonzero.
- R10: When R9 does not apply, a status write with bit 0 cleared while stored bit 0 was set withdraws the interrupt request.
- R11: The interrupt pulse lasts exactly one cycle. The request otherwise holds its value.
- R12: The read port returns the addressed register at once. It returns 0 for unknown numbers and for registers 16 or 28 with a nonzero select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe |
| wrReg | input | 5 | Register number to write |
| wrSel | input | 3 | Register select to write |
| wrData | input | 32 | Value to write |
| rdReg | input | 5 | Register number to read |
| rdSel | input | 3 | Register select to read |
| rdData | output | 32 | Read data |
| modeUser | output | 1 | User-mode flag |
| modeErrLvl | output | 1 | Error-level flag |
| modeExcLvl | output | 1 | Exception-level flag |
| modeDebug | output | 1 | Debug-mode flag |
| hwIrqReq | output | 1 | Hardware interrupt request |
| extIrqPulse | output | 1 | One-cycle external-interrupt pulse |

## Verification
The hardest case to reach is the interrupt raise. It needs a pending bit in the cause register, a stored enable of 0, and a status write that sets the enable and the matching mask bit while keeping every blocking flag clear. The only pending bits reachable from the ports are the two software bits of the cause register. The stimulus therefore writes those bits first and then builds the status write step by step. It also tries each blocking condition in turn: the exception bit, the error bit, debug mode, a mask bit that matches no pending bit, and an enable that was already set. A long random stream of writes across known and unknown numbers then runs with the reference model checking every cycle.

// File: rtl/sysctl_wr_pkg.sv
`timescale 1ns/1ps
package sysctl_wr_pkg;
  localparam int DATA_W   = 32;
  localparam int REG_W    = 5;
  localparam int SEL_W    = 3;
  localparam int NUM_REGS = 12;
  localparam int IDX_W    = $clog2(NUM_REGS);

  // Positions in the register table below
  localparam int STATUS_IDX = 1;
  localparam int CAUSE_IDX  = 2;
  localparam int DEBUG_IDX  = 7;

  // Bit positions the control path decodes
  localparam int ST_IE   = 0;
  localparam int ST_EXL  = 1;
  localparam int ST_ERL  = 2;
  localparam int ST_UM   = 4;
  localparam int IRQ_LO  = 8;
  localparam int IRQ_HI  = 15;
  localparam int DBG_DM  = 30;

  typedef struct packed {
    logic [REG_W-1:0]  num;
    logic              selZeroOnly;
    logic [DATA_W-1:0] keepMask;
    logic [DATA_W-1:0] takeMask;
  } regDesc_t;

  typedef struct packed {
    logic [NUM_REGS-1:0] regWr;
    logic                statusWr;
    logic                debugWr;
  } wrStrobe_t;

  function automatic regDesc_t regDesc(input int idx);
    regDesc_t d;
    d = '{num: '0, selZeroOnly: 1'b0, keepMask: '0, takeMask: '1};
    case (idx)
      0:  d.num = 5'd11;
      1:  begin d.num = 5'd12; d.takeMask = 32'hFA78_FF01; end
      2:  begin d.num = 5'd13; d.keepMask = 32'hB000_F87C; d.takeMask = 32'h00C0_0300; end
      3:  d.num = 5'd14;
      4:  begin d.num = 5'd16; d.selZeroOnly = 1'b1;
                d.keepMask = 32'h8017_FF80; d.takeMask = 32'h7E00_0001; end
      5:  d.num = 5'd18;
      6:  begin d.num = 5'd19; d.takeMask = 32'h40FF_0FF8; end
      7:  begin d.num = 5'd23; d.keepMask = 32'h8C03_FC1F; d.takeMask = 32'h1330_0120; end
      8:  d.num = 5'd24;
      9:  begin d.num = 5'd28; d.selZeroOnly = 1'b1; d.takeMask = 32'hFFFF_FCF6; end
      10: d.num = 5'd30;
      default: d.num = 5'd31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sysctl_wr_ctrl.sv
`timescale 1ns/1ps
module sysctl_wr_ctrl
  import sysctl_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrReg,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] statusQ,
  input  logic [DATA_W-1:0] causeQ,
  output wrStrobe_t         strobe,
  output logic              modeUser,
  output logic              modeErrLvl,
  output logic              modeExcLvl,
  output logic              modeDebug,
  output logic              hwIrqReq,
  output logic              extIrqPulse
);
  localparam regDesc_t STATUS_D = regDesc(STATUS_IDX);

  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam regDesc_t D = regDesc(i);
    always_comb begin
      hit[i] = wrEn && (wrReg == D.num) &&
               (!D.selZeroOnly || (wrSel == '0));
    end
  end

  always_comb begin
    strobe.regWr    = hit;
    strobe.statusWr = hit[STATUS_IDX];
    strobe.debugWr  = hit[DEBUG_IDX];
  end

  // Interrupt decision
  logic [DATA_W-1:0] statusNew;
  logic              unmaskedPend;
  logic              raiseIrq;
  logic              dropIrq;

  always_comb begin
    statusNew    = wrData & STATUS_D.takeMask;
    unmaskedPend = |(statusNew[IRQ_HI:IRQ_LO] & causeQ[IRQ_HI:IRQ_LO]);
    raiseIrq     = strobe.statusWr && wrData[ST_IE] && !statusQ[ST_IE] &&
                   !wrData[ST_EXL] && !wrData[ST_ERL] && !modeDebug &&
                   unmaskedPend;
    dropIrq      = strobe.statusWr && !wrData[ST_IE] && statusQ[ST_IE];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeUser    <= 1'b0;
      modeErrLvl  <= 1'b1;
      modeExcLvl  <= 1'b0;
      modeDebug   <= 1'b0;
      hwIrqReq    <= 1'b0;
      extIrqPulse <= 1'b0;
    end else begin
      if (strobe.statusWr) begin
        modeUser   <= wrData[ST_UM];
        modeErrLvl <= wrData[ST_ERL];
        modeExcLvl <= wrData[ST_EXL];
      end
      if (strobe.debugWr) modeDebug <= wrData[DBG_DM];
      if (raiseIrq)     hwIrqReq <= 1'b1;
      else if (dropIrq) hwIrqReq <= 1'b0;
      extIrqPulse <= raiseIrq;
    end
  end

  // R11: pulse is a single cycle and always comes with the request
  p_pulse_single_r11: assert property (@(posedge clk) disable iff (rst)
    extIrqPulse |=> !extIrqPulse);
  p_pulse_with_req_r11: assert property (@(posedge clk) disable iff (rst)
    extIrqPulse |-> hwIrqReq);
  // R9: a pulse only follows when enable is set and no blocking flag is set
  p_pulse_gated_r9: assert property (@(posedge clk) disable iff (rst)
    extIrqPulse |-> (statusQ[ST_IE] && !modeExcLvl && !modeErrLvl && !modeDebug));
  // R10: clearing the enable withdraws the request
  p_withdraw_r10: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrReg == STATUS_D.num && !wrData[ST_IE] && statusQ[ST_IE]) |=> !hwIrqReq);
endmodule

// File: rtl/sysctl_wr_dp.sv
`timescale 1ns/1ps
module sysctl_wr_dp
  import sysctl_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  wrStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [REG_W-1:0]  rdReg,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0] causeQ
);
  localparam regDesc_t STATUS_D = regDesc(STATUS_IDX);

  logic [NUM_REGS-1:0][DATA_W-1:0] regQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam regDesc_t D = regDesc(i);
    always_ff @(posedge clk) begin
      if (rst)                  regQ[i] <= '0;
      else if (strobe.regWr[i]) regQ[i] <= (regQ[i] & D.keepMask) | (wrData & D.takeMask);
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if ((rdReg == regDesc(i).num) && (!regDesc(i).selZeroOnly || (rdSel == '0)))
        rdData = rdData | regQ[i];
    end
  end

  assign statusQ = regQ[STATUS_IDX];
  assign causeQ  = regQ[CAUSE_IDX];

  // R8: at most one register is written, and no strobe leaves all state alone
  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe.regWr));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (strobe.regWr == '0) |=> $stable(regQ));
  // R2: status never holds a bit outside its storable set
  p_status_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (statusQ & ~STATUS_D.takeMask) == '0);
endmodule

// File: rtl/sysctl_wr_unit.sv
`timescale 1ns/1ps
module sysctl_wr_unit
  import sysctl_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrReg,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [REG_W-1:0]  rdReg,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              modeUser,
  output logic              modeErrLvl,
  output logic              modeExcLvl,
  output logic              modeDebug,
  output logic              hwIrqReq,
  output logic              extIrqPulse
);
  wrStrobe_t         strobe;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] causeQ;

  sysctl_wr_ctrl ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrReg(wrReg), .wrSel(wrSel),
    .wrData(wrData), .statusQ(statusQ), .causeQ(causeQ), .strobe(strobe),
    .modeUser(modeUser), .modeErrLvl(modeErrLvl), .modeExcLvl(modeExcLvl),
    .modeDebug(modeDebug), .hwIrqReq(hwIrqReq), .extIrqPulse(extIrqPulse)
  );

  sysctl_wr_dp dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData),
    .rdReg(rdReg), .rdSel(rdSel), .rdData(rdData),
    .statusQ(statusQ), .causeQ(causeQ)
  );
endmodule

// File: tb/sysctl_wr_unit_tb_top.sv
`timescale 1ns/1ps
module sysctl_wr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic [4:0]  wrReg;
  logic [2:0]  wrSel;
  logic [31:0] wrData;
  logic [4:0]  rdReg;
  logic [2:0]  rdSel;
  logic [31:0] rdData;
  logic        modeUser, modeErrLvl, modeExcLvl, modeDebug, hwIrqReq, extIrqPulse;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // Reference state
  logic [31:0] mReg [32];
  logic mUm, mErl, mExl, mDm, mIrq, mPulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_wr_unit dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrReg(wrReg), .wrSel(wrSel), .wrData(wrData),
    .rdReg(rdReg), .rdSel(rdSel), .rdData(rdData), .modeUser(modeUser),
    .modeErrLvl(modeErrLvl), .modeExcLvl(modeExcLvl), .modeDebug(modeDebug),
    .hwIrqReq(hwIrqReq), .extIrqPulse(extIrqPulse)
  );

  function automatic bit isKnown(int n);
    return n inside {11, 12, 13, 14, 16, 18, 19, 23, 24, 28, 30, 31};
  endfunction

  function automatic logic [31:0] modelRead(int n, int s);
    if (!isKnown(n)) return 32'h0;
    if ((n == 16 || n == 28) && s != 0) return 32'h0;
    return mReg[n];
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 32; i++) mReg[i] = 32'h0;
    mUm = 0; mErl = 1; mExl = 0; mDm = 0; mIrq = 0; mPulse = 0;
  endtask

  task automatic modelWrite(bit en, int n, int s, logic [31:0] d);
    logic [31:0] oldSt, newSt;
    bit raise;
    mPulse = 0;
    if (!en) return;
    case (n)
      11, 14, 18, 24, 30, 31: mReg[n] = d;
      12: begin
        oldSt = mReg[12];
        newSt = d & 32'hFA78_FF01;
        mReg[12] = newSt;
        mUm = d[4]; mErl = d[2]; mExl = d[1];
        raise = d[0] && !oldSt[0] && !d[1] && !d[2] && !mDm &&
                ((newSt[15:8] & mReg[13][15:8]) != 0);
        if (raise) mIrq = 1;
        else if (!d[0] && oldSt[0]) mIrq = 0;
        mPulse = raise;
      end
      13: mReg[13] = (mReg[13] & 32'hB000_F87C) | (d & 32'h00C0_0300);
      16: if (s == 0) mReg[16] = (mReg[16] & 32'h8017_FF80) | (d & 32'h7E00_0001);
      19: mReg[19] = d & 32'h40FF_0FF8;
      23: begin
        mReg[23] = (mReg[23] & 32'h8C03_FC1F) | (d & 32'h1330_0120);
        mDm = d[30];
      end
      28: if (s == 0) mReg[28] = d & 32'hFFFF_FCF6;
      default: ;
    endcase
  endtask

  task automatic check1(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called in the low half of the clock: compares flags and sweeps the read port
  task automatic compareAll(string req);
    check1(req, "modeUser", 32'(modeUser), 32'(mUm));
    check1(req, "modeErrLvl", 32'(modeErrLvl), 32'(mErl));
    check1(req, "modeExcLvl", 32'(modeExcLvl), 32'(mExl));
    check1(req, "modeDebug", 32'(modeDebug), 32'(mDm));
    check1(req, "hwIrqReq", 32'(hwIrqReq), 32'(mIrq));
    check1(req, "extIrqPulse", 32'(extIrqPulse), 32'(mPulse));
    for (int n = 0; n < 32; n++) begin
      rdReg = 5'(n); rdSel = 3'd0;
      #0.1;
      check1(req, $sformatf("R12 read reg %0d", n), rdData, modelRead(n, 0));
    end
    rdReg = 5'd16; rdSel = 3'd1; #0.1;
    check1("R12", "read 16 sel1", rdData, 32'h0);
    rdReg = 5'd28; rdSel = 3'd5; #0.1;
    check1("R12", "read 28 sel5", rdData, 32'h0);
  endtask

  task automatic applyWrite(bit en, int n, int s, logic [31:0] d, string req);
    @(negedge clk);
    wrEn = en; wrReg = 5'(n); wrSel = 3'(s); wrData = d;
    @(posedge clk);
    modelWrite(en, n, s, d);
    @(negedge clk);
    wrEn = 0;
    compareAll(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1; wrEn = 0; wrReg = 0; wrSel = 0; wrData = 0; rdReg = 0; rdSel = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    compareAll("R1");

    // R2: all ones with exception/error bits set: masked store, no raise
    applyWrite(1, 12, 0, 32'hFFFF_FFFF, "R2");
    // R3: cause software bits and high take bits
    applyWrite(1, 13, 0, 32'hFFFF_FFFF, "R3");
    // R10: enable cleared while set
    applyWrite(1, 12, 0, 32'h0000_0000, "R10");
    // R9: unmask a pending software bit with enable rising
    applyWrite(1, 12, 0, 32'h0000_0301, "R9");
    // R11: pulse drops, request holds
    applyWrite(0, 12, 0, 32'h0000_0000, "R11");
    // R9: enable already set, no new pulse
    applyWrite(1, 12, 0, 32'h0000_0301, "R9");
    // R10: withdraw
    applyWrite(1, 12, 0, 32'h0000_0300, "R10");
    // R4: debug mode set, then blocked raise
    applyWrite(1, 23, 0, 32'hFFFF_FFFF, "R4");
    applyWrite(1, 12, 0, 32'h0000_0301, "R9");
    applyWrite(1, 23, 0, 32'h0000_0000, "R4");
    applyWrite(1, 12, 0, 32'h0000_0000, "R10");
    // R9: error bit blocks, then mask without pending bit blocks
    applyWrite(1, 12, 0, 32'h0000_0305, "R9");
    applyWrite(1, 12, 0, 32'h0000_0000, "R10");
    applyWrite(1, 12, 0, 32'h0000_FC01, "R9");
    applyWrite(1, 12, 0, 32'h0000_0000, "R10");
    // R5, R6, R7
    applyWrite(1, 16, 0, 32'hFFFF_FFFF, "R5");
    applyWrite(1, 19, 0, 32'hFFFF_FFFF, "R6");
    applyWrite(1, 28, 0, 32'hFFFF_FFFF, "R6");
    applyWrite(1, 11, 3, 32'hDEAD_BEEF, "R7");
    applyWrite(1, 14, 0, 32'h1234_5678, "R7");
    applyWrite(1, 18, 7, 32'h8000_0001, "R7");
    applyWrite(1, 24, 0, 32'hCAFE_F00D, "R7");
    applyWrite(1, 30, 1, 32'h0F0F_F0F0, "R7");
    applyWrite(1, 31, 0, 32'hA5A5_5A5A, "R7");
    // R8: ignored writes
    applyWrite(1, 16, 1, 32'h0000_0000, "R8");
    applyWrite(1, 28, 2, 32'h0000_0000, "R8");
    applyWrite(1, 5, 0, 32'hFFFF_FFFF, "R8");
    applyWrite(0, 14, 0, 32'h0000_0000, "R8");
    applyWrite(1, 13, 0, 32'h0000_0000, "R3");

    // Random stream
    for (int k = 0; k < 400; k++) begin
      int pick;
      int num;
      int sel;
      logic [31:0] d;
      pick = int'($urandom_range(0, 15));
      case (pick)
        0, 1, 2: num = 12;
        3, 4:    num = 13;
        5:       num = 23;
        6:       num = 16;
        7:       num = 28;
        8:       num = int'($urandom_range(0, 10));
        default: num = int'($urandom_range(11, 31));
      endcase
      sel = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 7)) : 0;
      d = $urandom;
      if (num == 12 && $urandom_range(0, 1) == 1) d = d & 32'hFFFF_FFF9;
      applyWrite($urandom_range(0, 7) != 0, num, sel, d, "R9");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule